// File: doc/BRIEF.md
# Programmable Asynchronous Multiplexed-Bus Cycle Generator

This block runs a single asynchronous read or write transaction on an external memory bus whose 16-bit address and data lines are shared (AD bus). A host-side request supplies a direction, an address and, for writes, a data word. Once the request is taken, one tick counter starts at zero and advances by one each clock. Every edge of the four active-low strobes is set by its own programmable tick count: chip select, address-valid, output enable and write enable. So are the point where read data is sampled, the point where write data replaces the address on the AD bus, the point where the write drive is released, and the end of the cycle. Reads and writes have separate chip-select and address-valid release points and separate cycle lengths.

The timing counts are presented on input ports. They are copied into registers, together with the request, on the clock edge that accepts the request. The cycle therefore runs to completion with the values it started with. The AD bus is modelled as a split output, drive-enable and input trio. On reads the block drives the address until address-valid is released and then lets the bus float. The value on the bus during the programmed access tick is captured into a read-data register. When the cycle ends, all strobes return high, a one-clock done pulse is given, and a new request can be accepted in that same clock. This allows zero dead time between cycles.

Top module: `async_bus_cycle_gen`

## Requirements
- R1: While reset is asserted, and from the first clock after its release: cs_n, adv_n, oe_n and we_n are 1, ad_oe and done are 0 and req_ready is 1. Asserting reset during a cycle returns the outputs to this state without waiting for a clock.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from that edge until the cycle's done clock. A request offered while req_ready is 0 is ignored and does not disturb the running cycle.
- R3: Tick 0 is the clock after the accepting edge. cs_n is 0 on ticks t where cs_on <= t < cs_off, and 1 otherwise. cs_off is the read or the write chip-select release count, chosen by direction.
- R4: adv_n is 0 on ticks t where adv_on <= t < adv_off. adv_off is the read or the write address-valid release count, chosen by direction.
- R5: On reads, oe_n is 0 on ticks oe_on <= t < oe_off. On writes, oe_n stays 1.
- R6: On writes, we_n is 0 on ticks we_on <= t < we_off. On reads, we_n stays 1.
- R7: On reads, ad_oe is 1 and ad_out equals the request address on ticks t < read address-valid release. From that tick on, ad_oe is 0.
- R8: On writes, ad_oe is 1 on ticks t < write access count. ad_out carries the address on ticks t < write-mux count and the write data from that tick on.
- R9: On reads, rdata takes the ad_in value present during tick read-access. rdata changes at no other time, and writes leave it unchanged.
- R10: When the tick reaches the cycle length (read or write count, minimum 1), done is 1 for exactly that one clock. In that clock all strobes are 1, ad_oe is 0 and req_ready is 1. A request offered in that clock is accepted, and its tick 0 follows immediately.
- R11: Timing inputs are sampled only on the accepting edge. Changing them during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AD_W | Address placed on AD bus |
| req_wdata | input | AD_W | Write data |
| req_ready | output | 1 | Idle, request can be accepted |
| done | output | 1 | One-clock pulse at cycle end |
| rdata | output | AD_W | Captured read data |
| t_cs_on | input | TICK_W | Chip-select assert tick |
| t_cs_rd_off | input | TICK_W | Chip-select release tick, reads |
| t_cs_wr_off | input | TICK_W | Chip-select release tick, writes |
| t_adv_on | input | TICK_W | Address-valid assert tick |
| t_adv_rd_off | input | TICK_W | Address-valid release tick, reads |
| t_adv_wr_off | input | TICK_W | Address-valid release tick, writes |
| t_oe_on | input | TICK_W | Output-enable assert tick |
| t_oe_off | input | TICK_W | Output-enable release tick |
| t_we_on | input | TICK_W | Write-enable assert tick |
| t_we_off | input | TICK_W | Write-enable release tick |
| t_rd_access | input | TICK_W | Read sample tick |
| t_wr_access | input | TICK_W | Write drive release tick |
| t_rd_cycle | input | TICK_W | Read cycle length |
| t_wr_cycle | input | TICK_W | Write cycle length |
| t_wr_mux | input | TICK_W | Tick where write data replaces address |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ad_out | output | AD_W | AD bus drive value |
| ad_oe | output | 1 | AD bus drive enable |
| ad_in | input | AD_W | AD bus sampled value |

## Verification
Two functions can land on the same clock edge. The first pair is the end of one cycle and the acceptance of the next. A request is raised during the done clock, and the checks confirm that the next cycle's tick 0 strobes appear in the very next clock. The second pair is the read-data capture and the cycle end. A read with a cycle length of 1 and an access tick of 0 makes the sampling edge and the finishing edge the same edge. The captured word is then compared against the value the bench drove only during that tick.

// File: rtl/abcg_pkg.sv
package abcg_pkg;
  // Index of each timing field inside the packed timing vector.
  localparam int unsigned F_CS_ON      = 0;
  localparam int unsigned F_CS_RD_OFF  = 1;
  localparam int unsigned F_CS_WR_OFF  = 2;
  localparam int unsigned F_ADV_ON     = 3;
  localparam int unsigned F_ADV_RD_OFF = 4;
  localparam int unsigned F_ADV_WR_OFF = 5;
  localparam int unsigned F_OE_ON      = 6;
  localparam int unsigned F_OE_OFF     = 7;
  localparam int unsigned F_WE_ON      = 8;
  localparam int unsigned F_WE_OFF     = 9;
  localparam int unsigned F_RD_ACC     = 10;
  localparam int unsigned F_WR_ACC     = 11;
  localparam int unsigned F_RD_CYC     = 12;
  localparam int unsigned F_WR_CYC     = 13;
  localparam int unsigned F_WR_MUX     = 14;
  localparam int unsigned N_FIELDS     = 15;

  // Strobe activity, 1 = asserted (pins are active low).
  typedef struct packed {
    logic cs;
    logic adv;
    logic oe;
    logic we;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '0;
endpackage

// File: rtl/abcg_snapshot.sv
module abcg_snapshot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (load) q_d = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/abcg_tick_seq.sv
module abcg_tick_seq #(
  parameter int unsigned TICK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TICK_W-1:0] cyc_len,
  output logic              busy,
  output logic [TICK_W-1:0] tick,
  output logic [TICK_W-1:0] tick_next,
  output logic              finish,
  output logic              done
);
  logic              busy_d, busy_q;
  logic [TICK_W-1:0] tick_d, tick_q;
  logic              done_d, done_q;
  logic [TICK_W:0]   inc;

  assign inc    = {1'b0, tick_q} + 1'b1;
  assign finish = busy_q && (inc >= {1'b0, cyc_len});

  always_comb begin
    busy_d    = busy_q;
    tick_d    = tick_q;
    done_d    = finish;
    tick_next = inc[TICK_W-1:0];
    if (start) begin
      busy_d    = 1'b1;
      tick_d    = '0;
      tick_next = '0;
    end else if (finish) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      tick_d = inc[TICK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      tick_q <= tick_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign tick = tick_q;
  assign done = done_q;
endmodule

// File: rtl/abcg_strobe_dec.sv
module abcg_strobe_dec
  import abcg_pkg::*;
#(
  parameter int unsigned TICK_W = 9
) (
  input  logic [TICK_W-1:0] tick,
  input  logic              is_wr,
  input  logic [TICK_W-1:0] cs_on,
  input  logic [TICK_W-1:0] cs_off,
  input  logic [TICK_W-1:0] adv_on,
  input  logic [TICK_W-1:0] adv_off,
  input  logic [TICK_W-1:0] oe_on,
  input  logic [TICK_W-1:0] oe_off,
  input  logic [TICK_W-1:0] we_on,
  input  logic [TICK_W-1:0] we_off,
  input  logic [TICK_W-1:0] drive_end,
  input  logic [TICK_W-1:0] mux_at,
  output strobe_t           act,
  output logic              ad_drive,
  output logic              ad_wsel
);
  function automatic logic in_win(input logic [TICK_W-1:0] t,
                                  input logic [TICK_W-1:0] lo,
                                  input logic [TICK_W-1:0] hi);
    return (t >= lo) && (t < hi);
  endfunction

  always_comb begin
    act.cs   = in_win(tick, cs_on, cs_off);
    act.adv  = in_win(tick, adv_on, adv_off);
    act.oe   = !is_wr && in_win(tick, oe_on, oe_off);
    act.we   =  is_wr && in_win(tick, we_on, we_off);
    ad_drive = tick < drive_end;
    ad_wsel  = is_wr && (tick >= mux_at);
  end
endmodule

// File: rtl/abcg_ad_path.sv
module abcg_ad_path #(
  parameter int unsigned AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            drive_next,
  input  logic            wsel_next,
  input  logic [AD_W-1:0] addr,
  input  logic [AD_W-1:0] wdata,
  input  logic            capture,
  input  logic [AD_W-1:0] ad_in,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_oe,
  output logic [AD_W-1:0] rdata
);
  logic [AD_W-1:0] out_d, out_q;
  logic            oe_d, oe_q;
  logic [AD_W-1:0] rd_d, rd_q;

  always_comb begin
    out_d = out_q;
    oe_d  = 1'b0;
    rd_d  = rd_q;
    if (load) begin
      oe_d  = drive_next;
      out_d = wsel_next ? wdata : addr;
    end
    if (capture) rd_d = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
      rd_q  <= rd_d;
    end
  end

  assign ad_out = out_q;
  assign ad_oe  = oe_q;
  assign rdata  = rd_q;
endmodule

// File: rtl/async_bus_cycle_gen.sv
module async_bus_cycle_gen
  import abcg_pkg::*;
#(
  parameter int unsigned TICK_W = 9,
  parameter int unsigned AD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AD_W-1:0]   req_addr,
  input  logic [AD_W-1:0]   req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [AD_W-1:0]   rdata,
  input  logic [TICK_W-1:0] t_cs_on,
  input  logic [TICK_W-1:0] t_cs_rd_off,
  input  logic [TICK_W-1:0] t_cs_wr_off,
  input  logic [TICK_W-1:0] t_adv_on,
  input  logic [TICK_W-1:0] t_adv_rd_off,
  input  logic [TICK_W-1:0] t_adv_wr_off,
  input  logic [TICK_W-1:0] t_oe_on,
  input  logic [TICK_W-1:0] t_oe_off,
  input  logic [TICK_W-1:0] t_we_on,
  input  logic [TICK_W-1:0] t_we_off,
  input  logic [TICK_W-1:0] t_rd_access,
  input  logic [TICK_W-1:0] t_wr_access,
  input  logic [TICK_W-1:0] t_rd_cycle,
  input  logic [TICK_W-1:0] t_wr_cycle,
  input  logic [TICK_W-1:0] t_wr_mux,
  output logic              cs_n,
  output logic              adv_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  input  logic [AD_W-1:0]   ad_in
);
  localparam int unsigned CFG_W  = N_FIELDS * TICK_W;
  localparam int unsigned SNAP_W = 1 + 2 * AD_W + CFG_W;

  logic [N_FIELDS-1:0][TICK_W-1:0] cfg_in, cfg_q, cfg_eff;
  logic [SNAP_W-1:0] snap_in, snap_q;
  logic              wr_q, wr_eff;
  logic [AD_W-1:0]   addr_q, wdata_q, addr_eff, wdata_eff;

  logic              busy, finish, start, load, capture;
  logic [TICK_W-1:0] tick, tick_next, cyc_len;
  strobe_t           dec_act, strobe_d, strobe_q;
  logic              dec_drive, dec_wsel;

  // Pack timing inputs into the indexed vector.
  always_comb begin
    cfg_in               = '0;
    cfg_in[F_CS_ON]      = t_cs_on;
    cfg_in[F_CS_RD_OFF]  = t_cs_rd_off;
    cfg_in[F_CS_WR_OFF]  = t_cs_wr_off;
    cfg_in[F_ADV_ON]     = t_adv_on;
    cfg_in[F_ADV_RD_OFF] = t_adv_rd_off;
    cfg_in[F_ADV_WR_OFF] = t_adv_wr_off;
    cfg_in[F_OE_ON]      = t_oe_on;
    cfg_in[F_OE_OFF]     = t_oe_off;
    cfg_in[F_WE_ON]      = t_we_on;
    cfg_in[F_WE_OFF]     = t_we_off;
    cfg_in[F_RD_ACC]     = t_rd_access;
    cfg_in[F_WR_ACC]     = t_wr_access;
    cfg_in[F_RD_CYC]     = t_rd_cycle;
    cfg_in[F_WR_CYC]     = t_wr_cycle;
    cfg_in[F_WR_MUX]     = t_wr_mux;
  end

  assign req_ready = ~busy;
  assign start     = req_valid & ~busy;
  assign snap_in   = {req_write, req_addr, req_wdata, cfg_in};

  abcg_snapshot #(.W(SNAP_W)) u_snap (
    .clk  (clk),
    .rst_n(rst_n),
    .load (start),
    .d_in (snap_in),
    .q    (snap_q)
  );

  assign {wr_q, addr_q, wdata_q, cfg_q} = snap_q;

  // The accepting clock decodes tick 0 from the live request.
  assign wr_eff    = start ? req_write : wr_q;
  assign addr_eff  = start ? req_addr  : addr_q;
  assign wdata_eff = start ? req_wdata : wdata_q;
  assign cfg_eff   = start ? cfg_in    : cfg_q;
  assign cyc_len   = wr_q ? cfg_q[F_WR_CYC] : cfg_q[F_RD_CYC];

  abcg_tick_seq #(.TICK_W(TICK_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cyc_len  (cyc_len),
    .busy     (busy),
    .tick     (tick),
    .tick_next(tick_next),
    .finish   (finish),
    .done     (done)
  );

  abcg_strobe_dec #(.TICK_W(TICK_W)) u_dec (
    .tick     (tick_next),
    .is_wr    (wr_eff),
    .cs_on    (cfg_eff[F_CS_ON]),
    .cs_off   (wr_eff ? cfg_eff[F_CS_WR_OFF]  : cfg_eff[F_CS_RD_OFF]),
    .adv_on   (cfg_eff[F_ADV_ON]),
    .adv_off  (wr_eff ? cfg_eff[F_ADV_WR_OFF] : cfg_eff[F_ADV_RD_OFF]),
    .oe_on    (cfg_eff[F_OE_ON]),
    .oe_off   (cfg_eff[F_OE_OFF]),
    .we_on    (cfg_eff[F_WE_ON]),
    .we_off   (cfg_eff[F_WE_OFF]),
    .drive_end(wr_eff ? cfg_eff[F_WR_ACC]     : cfg_eff[F_ADV_RD_OFF]),
    .mux_at   (cfg_eff[F_WR_MUX]),
    .act      (dec_act),
    .ad_drive (dec_drive),
    .ad_wsel  (dec_wsel)
  );

  assign load = start | (busy & ~finish);

  always_comb begin
    strobe_d = STROBE_IDLE;
    if (load) strobe_d = dec_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= STROBE_IDLE;
    else        strobe_q <= strobe_d;
  end

  assign capture = busy & ~wr_q & (tick == cfg_q[F_RD_ACC]);

  abcg_ad_path #(.AD_W(AD_W)) u_ad (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .drive_next(dec_drive),
    .wsel_next (dec_wsel),
    .addr      (addr_eff),
    .wdata     (wdata_eff),
    .capture   (capture),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .rdata     (rdata)
  );

  assign cs_n  = ~strobe_q.cs;
  assign adv_n = ~strobe_q.adv;
  assign oe_n  = ~strobe_q.oe;
  assign we_n  = ~strobe_q.we;
endmodule

// File: rtl/abcg_checker.sv
module abcg_checker #(
  parameter int unsigned AD_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            done,
  input logic            cs_n,
  input logic            adv_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            ad_oe,
  input logic [AD_W-1:0] rdata
);
  // R1: an idle engine holds every strobe inactive
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !(req_valid)) |-> (cs_n && adv_n && oe_n && we_n && !ad_oe));

  // R2: acceptance makes the engine busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5 / R6: the two enables never overlap
  a_r5_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R10: done is a single clock and the bus is quiet then
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && adv_n && oe_n && we_n && !ad_oe && req_ready));

  // R9: read data only moves while a cycle runs
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(!req_ready));
endmodule

bind async_bus_cycle_gen abcg_checker #(.AD_W(AD_W)) u_abcg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .cs_n     (cs_n),
  .adv_n    (adv_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .ad_oe    (ad_oe),
  .rdata    (rdata)
);

// File: tb/test_async_bus_cycle_gen.sv
module test_async_bus_cycle_gen;
  localparam int TW = 9;
  localparam int AW = 16;

  logic clk, rst_n;
  logic req_valid, req_write, req_ready, done;
  logic [AW-1:0] req_addr, req_wdata, rdata, ad_out, ad_in;
  logic cs_n, adv_n, oe_n, we_n, ad_oe;
  logic [TW-1:0] cfg [15];
  int mdl [15];
  int tests, fails;

  async_bus_cycle_gen #(.TICK_W(TW), .AD_W(AW)) i_async_bus_cycle_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata),
    .t_cs_on(cfg[0]), .t_cs_rd_off(cfg[1]), .t_cs_wr_off(cfg[2]),
    .t_adv_on(cfg[3]), .t_adv_rd_off(cfg[4]), .t_adv_wr_off(cfg[5]),
    .t_oe_on(cfg[6]), .t_oe_off(cfg[7]), .t_we_on(cfg[8]), .t_we_off(cfg[9]),
    .t_rd_access(cfg[10]), .t_wr_access(cfg[11]), .t_rd_cycle(cfg[12]),
    .t_wr_cycle(cfg[13]), .t_wr_mux(cfg[14]),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {write, addr, wdata, value returned by the memory on reads}
  localparam logic [48:0] VEC [6] = '{
    {1'b0, 16'h1234, 16'h0000, 16'hA5C3},
    {1'b1, 16'h0040, 16'hBEEF, 16'h0000},
    {1'b0, 16'hFFFE, 16'h0000, 16'h0001},
    {1'b1, 16'h8001, 16'h0F0F, 16'h0000},
    {1'b0, 16'h0000, 16'h0000, 16'hFFFF},
    {1'b1, 16'h7FFF, 16'h5555, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_timing(input int v [15]);
    for (int i = 0; i < 15; i++) begin
      cfg[i] = v[i][TW-1:0];
      mdl[i] = v[i];
    end
  endtask

  function automatic bit win(input int t, input int lo, input int hi);
    return (t >= lo) && (t < hi);
  endfunction

  // Called at the negedge of the clock following an accepting edge (tick 0).
  task automatic track(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [15:0] rv, input int poke_t, input int mut_t,
                       input bit chain, input bit cwr, input logic [15:0] ca,
                       input logic [15:0] cd);
    int len;
    bit e_cs, e_adv, e_oe, e_we, e_drv;
    len = wr ? mdl[13] : mdl[12];
    for (int t = 0; t <= len; t++) begin
      if (t == len) begin
        chk("R10 done at end", {31'd0, done}, 32'd1);
        chk("R10 strobes idle at end", {28'd0, cs_n, adv_n, oe_n, we_n}, 32'hF);
        chk("R10 bus released at end", {31'd0, ad_oe}, 32'd0);
        chk("R10 ready at end", {31'd0, req_ready}, 32'd1);
      end else begin
        e_cs  = win(t, mdl[0], wr ? mdl[2] : mdl[1]);
        e_adv = win(t, mdl[3], wr ? mdl[5] : mdl[4]);
        e_oe  = !wr && win(t, mdl[6], mdl[7]);
        e_we  = wr && win(t, mdl[8], mdl[9]);
        e_drv = wr ? (t < mdl[11]) : (t < mdl[4]);
        chk($sformatf("R3 cs_n tick %0d", t), {31'd0, cs_n}, {31'd0, !e_cs});
        chk($sformatf("R4 adv_n tick %0d", t), {31'd0, adv_n}, {31'd0, !e_adv});
        chk($sformatf("R5 oe_n tick %0d", t), {31'd0, oe_n}, {31'd0, !e_oe});
        chk($sformatf("R6 we_n tick %0d", t), {31'd0, we_n}, {31'd0, !e_we});
        chk($sformatf("%s ad_oe tick %0d", wr ? "R8" : "R7", t), {31'd0, ad_oe}, {31'd0, e_drv});
        if (e_drv)
          chk($sformatf("%s ad_out tick %0d", wr ? "R8" : "R7", t), {16'd0, ad_out},
              {16'd0, (wr && t >= mdl[14]) ? d : a});
        chk($sformatf("R2 busy tick %0d", t), {30'd0, req_ready, done}, 32'd0);
      end
      ad_in = (t == mdl[10]) ? rv : 16'(32'h5A00 + t);
      if (t == len && chain) begin
        req_valid = 1'b1; req_write = cwr; req_addr = ca; req_wdata = cd;
      end else if (t == poke_t) begin
        req_valid = 1'b1; req_write = !wr; req_addr = 16'hFFFF; req_wdata = 16'hFFFF;
      end else begin
        req_valid = 1'b0;
      end
      if (t == mut_t)
        for (int i = 0; i < 15; i++) cfg[i] = 9'd1;
      @(posedge clk);
      @(negedge clk);
    end
    if (!chain) begin
      req_valid = 1'b0;
      chk("R10 done lasts one clock", {31'd0, done}, 32'd0);
    end
  endtask

  task automatic start(input bit wr, input logic [15:0] a, input logic [15:0] d);
    chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ta [15] = '{0, 31, 31, 2, 8, 8, 9, 28, 9, 28, 19, 31, 31, 31, 15};
    int tb [15] = '{1, 3, 4, 0, 1, 1, 1, 3, 2, 3, 2, 3, 4, 4, 1};
    int tc [15] = '{1, 3, 4, 0, 1, 1, 1, 3, 2, 3, 0, 3, 1, 4, 1};
    logic [15:0] last_rd;
    tests = 0; fails = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; ad_in = '0;
    set_timing(ta);
    #1;
    chk("R1 strobes in reset", {28'd0, cs_n, adv_n, oe_n, we_n}, 32'hF);
    chk("R1 bus and done in reset", {30'd0, ad_oe, done}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 strobes after reset", {28'd0, cs_n, adv_n, oe_n, we_n}, 32'hF);

    // Table walk with the scaled example timing.
    last_rd = 16'h0000;
    for (int i = 0; i < 6; i++) begin
      start(VEC[i][48], VEC[i][47:32], VEC[i][31:16]);
      track(VEC[i][48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], -1, -1,
            1'b0, 1'b0, 16'h0, 16'h0);
      if (!VEC[i][48]) last_rd = VEC[i][15:0];
      chk($sformatf("R9 rdata after vector %0d", i), {16'd0, rdata}, {16'd0, last_rd});
    end

    // R2: request during busy is ignored; R11: timing change mid-cycle ignored.
    start(1'b0, 16'h2468, 16'h0);
    track(1'b0, 16'h2468, 16'h0, 16'h1357, 3, 5, 1'b0, 1'b0, 16'h0, 16'h0);
    chk("R11 read data with live timing altered", {16'd0, rdata}, 32'h1357);
    chk("R2 poke not accepted", {31'd0, req_ready}, 32'd1);
    set_timing(ta);

    // R10: zero-gap chain, short timing: read -> write -> read.
    set_timing(tb);
    start(1'b0, 16'h0102, 16'h0);
    track(1'b0, 16'h0102, 16'h0, 16'hC0DE, -1, -1, 1'b1, 1'b1, 16'h0304, 16'hD00D);
    track(1'b1, 16'h0304, 16'hD00D, 16'h0, -1, -1, 1'b1, 1'b0, 16'h0506, 16'h0);
    chk("R9 rdata kept across write", {16'd0, rdata}, 32'hC0DE);
    track(1'b0, 16'h0506, 16'h0, 16'h4242, -1, -1, 1'b0, 1'b0, 16'h0, 16'h0);
    chk("R10 chained read data", {16'd0, rdata}, 32'h4242);

    // R9 with R10: one-tick read, capture on the finishing edge.
    set_timing(tc);
    start(1'b0, 16'h0A0B, 16'h0);
    track(1'b0, 16'h0A0B, 16'h0, 16'h6C6C, -1, -1, 1'b0, 1'b0, 16'h0, 16'h0);
    chk("R9 capture on last tick", {16'd0, rdata}, 32'h6C6C);

    // R1: asynchronous reset in the middle of a cycle.
    set_timing(ta);
    start(1'b0, 16'h3333, 16'h0);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 strobes on mid-cycle reset", {28'd0, cs_n, adv_n, oe_n, we_n}, 32'hF);
    chk("R1 bus released on mid-cycle reset", {31'd0, ad_oe}, 32'd0);
    chk("R1 ready on mid-cycle reset", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 quiet after reset release", {27'd0, cs_n, adv_n, oe_n, we_n, done}, 32'h1E);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule